// File: doc/BRIEF.md
# Multi-channel debug word FIFO

This block sits on a processor's register bus and moves 32-bit words to and from an external debug host over up to sixteen logical channels. Software pushes a word toward the host by writing it to one of sixteen per-channel transmit addresses. The address picks the channel, and that channel number travels with the word through a transmit FIFO to a valid/ready stream on the host side. In the other direction, the host offers words together with a 4-bit channel tag. These fill a receive FIFO. Software first looks at the status register to see which channel owns the oldest word, then reads the receive address to take that word out.

A configuration register holds two 2-bit interrupt threshold selectors, one for each FIFO. The single level-sensitive interrupt output is high while the transmit condition, the receive condition, or both hold. The transport to the host and the bus fabric are outside this block.

Top module: `dbgchan_fifo_periph`

## Requirements
- R1: After reset both FIFOs are empty, the threshold selectors are 0 and `irq` is low. A status read returns 0x0000000A.
- R2: Reading offset 0x08 returns the TX depth in bits 15:8 and the RX depth in bits 7:0, with the threshold selectors in bits 19:16. A write to 0x08 changes only bits 19:16.
- R3: A write to offset 0x20 + 8·n (n = 0..15) queues the write data tagged with channel n. The host side presents queued words oldest first on `tx_data`/`tx_chan`, with `tx_valid` high exactly while words are queued. A word leaves on a cycle where `tx_valid` and `tx_ready` are both high.
- R4: A transmit write while the TX FIFO holds its full depth is dropped. Occupancy and queued contents stay as they were.
- R5: `rx_ready` is high while the RX FIFO is not full, and a word is accepted when `rx_valid` and `rx_ready` are both high. Status bits 7:4 give the channel of the oldest RX word. A read of offset 0x18 returns that word and removes it.
- R6: A read of 0x18 with the RX FIFO empty returns 0 and leaves the FIFO unchanged.
- R7: The status register at 0x10 holds TX occupancy in bits 31:24 and RX occupancy in bits 23:16. Bit 3 is RX empty, bit 2 is RX full, bit 1 is TX empty and bit 0 is TX full. Bits 7:4 read 0 when the RX FIFO is empty, and all other bits read 0.
- R8: The TX selector (bits 19:18) raises the TX condition as follows: 0 never; 1 when TX is empty; 2 when TX is not full; 3 when 4·occupancy ≤ depth.
- R9: The RX selector (bits 17:16) raises the RX condition as follows: 0 never; 1 when RX is full; 2 when RX is not empty; 3 when 4·occupancy ≥ 3·depth. `irq` is the OR of the TX and RX conditions, evaluated on the current state.
- R10: An accepted push and a pop on the same FIFO in the same cycle leave its occupancy unchanged and keep word order.
- R11: Offset 0x00, the transmit offsets, unaligned and unmapped offsets all read 0. Writes to 0x00, 0x10, 0x18 and to unmapped or unaligned offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read data is valid in the same cycle) |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (0 when not reading) |
| tx_valid | output | 1 | A word is available for the host |
| tx_ready | input | 1 | Host takes the word |
| tx_data | output | 32 | Oldest TX word |
| tx_chan | output | 4 | Channel of the oldest TX word |
| rx_valid | input | 1 | Host offers a word |
| rx_ready | output | 1 | RX FIFO can accept |
| rx_data | input | 32 | Offered word |
| rx_chan | input | 4 | Channel of the offered word |
| irq | output | 1 | Level interrupt |

## Verification
Two operations can land on one FIFO in the same clock: on the TX side a bus write and a host-side take, and on the RX side a host offer and a bus read of 0x18. The bench forces both pairs into single cycles. It also drives a long pseudo-random stretch in which strobes, readiness and threshold rewrites collide freely. A queue-based model tracks the occupancy, the word order, `irq` and every read value on each clock. That model includes the case where a write lands on a full TX FIFO in the same cycle as a take, and that write is still dropped.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int CHAN_W = 4;
  localparam int NCHAN  = 16;
  localparam int WORD_W = 32;

  localparam logic [7:0] OFF_ACC  = 8'h00;
  localparam logic [7:0] OFF_CFG  = 8'h08;
  localparam logic [7:0] OFF_STAT = 8'h10;
  localparam logic [7:0] OFF_RXD  = 8'h18;
  localparam logic [7:0] OFF_TXB  = 8'h20;

  typedef enum logic [1:0] {TXT_OFF = 2'd0, TXT_DRAINED = 2'd1,
                            TXT_ROOM = 2'd2, TXT_LOW = 2'd3} tx_thr_e;
  typedef enum logic [1:0] {RXT_OFF = 2'd0, RXT_FULL = 2'd1,
                            RXT_ANY = 2'd2, RXT_HIGH = 2'd3} rx_thr_e;
  typedef enum logic [1:0] {RSEL_ZERO, RSEL_CFG, RSEL_STAT, RSEL_RXD} rsel_e;

  // occupancy at or below a quarter of the depth
  function automatic logic quarter_low(input int unsigned cnt, input int unsigned depth);
    return (cnt * 4) <= depth;
  endfunction

  // occupancy at or above three quarters of the depth
  function automatic logic quarter_high(input int unsigned cnt, input int unsigned depth);
    return (cnt * 4) >= (depth * 3);
  endfunction
endpackage

// File: rtl/dcf_tag_fifo.sv
module dcf_tag_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int TW    = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic [TW-1:0] push_tag,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [TW-1:0] head_tag,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem_d [DEPTH];
  logic [TW-1:0] mem_t [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      if (push_ok && !pop_ok)      count <= count + CW'(1);
      else if (pop_ok && !push_ok) count <= count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem_d[wr_ptr] <= push_data;
      mem_t[wr_ptr] <= push_tag;
    end
  end

  assign head_data = mem_d[rd_ptr];
  assign head_tag  = mem_t[rd_ptr];
endmodule

// File: rtl/dcf_regdec.sv
module dcf_regdec
  import dcf_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  output logic              cfg_we,
  output logic              tx_we,
  output logic [CHAN_W-1:0] tx_sel_chan,
  output logic              rx_rd_req,
  output rsel_e             rsel
);
  localparam int unsigned TXB_IDX = 32'(OFF_TXB) >> 3;
  int unsigned idx_u;
  logic aligned, tx_hit;

  assign aligned     = (bus_addr[2:0] == 3'b000);
  assign idx_u       = 32'(bus_addr) >> 3;
  assign tx_hit      = aligned && (idx_u >= TXB_IDX) && (idx_u < TXB_IDX + NCHAN);
  assign tx_we       = bus_wr && tx_hit;
  assign tx_sel_chan = CHAN_W'(idx_u - TXB_IDX);
  assign cfg_we      = bus_wr && (bus_addr == AW'(OFF_CFG));
  assign rx_rd_req   = bus_rd && (bus_addr == AW'(OFF_RXD));

  always_comb begin
    rsel = RSEL_ZERO;
    if (bus_rd) begin
      if (bus_addr == AW'(OFF_CFG))       rsel = RSEL_CFG;
      else if (bus_addr == AW'(OFF_STAT)) rsel = RSEL_STAT;
      else if (bus_addr == AW'(OFF_RXD))  rsel = RSEL_RXD;
    end
  end
endmodule

// File: rtl/dcf_thr_eval.sv
module dcf_thr_eval
  import dcf_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter bit RX_SIDE = 1'b0,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic [1:0]    mode,
  input  logic [CW-1:0] count,
  output logic          hit
);
  generate
    if (RX_SIDE) begin : g_rx
      always_comb begin
        case (rx_thr_e'(mode))
          RXT_FULL: hit = (count == CW'(DEPTH));
          RXT_ANY:  hit = (count != '0);
          RXT_HIGH: hit = quarter_high(32'(count), DEPTH);
          default:  hit = 1'b0;
        endcase
      end
    end else begin : g_tx
      always_comb begin
        case (tx_thr_e'(mode))
          TXT_DRAINED: hit = (count == '0);
          TXT_ROOM:    hit = (count != CW'(DEPTH));
          TXT_LOW:     hit = quarter_low(32'(count), DEPTH);
          default:     hit = 1'b0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/dbgchan_fifo_periph.sv
module dbgchan_fifo_periph
  import dcf_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int AW       = 8,
  localparam int TX_CW   = $clog2(TX_DEPTH + 1),
  localparam int RX_CW   = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  output logic [CHAN_W-1:0] tx_chan,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [WORD_W-1:0] rx_data,
  input  logic [CHAN_W-1:0] rx_chan,
  output logic              irq
);
  logic              cfg_we, tx_we, rx_rd_req;
  logic [CHAN_W-1:0] tx_sel_chan;
  rsel_e             rsel;
  logic [3:0]        cfg_thr;
  logic [TX_CW-1:0]  tx_cnt;
  logic [RX_CW-1:0]  rx_cnt;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [WORD_W-1:0] rx_head_data;
  logic [CHAN_W-1:0] rx_head_chan;
  logic              tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic              tx_hit, rx_hit;
  logic [WORD_W-1:0] cfg_word, stat_word;

  dcf_regdec #(.AW(AW)) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .cfg_we(cfg_we), .tx_we(tx_we), .tx_sel_chan(tx_sel_chan),
    .rx_rd_req(rx_rd_req), .rsel(rsel)
  );

  // named transfer events
  assign tx_push_ok = tx_we && !tx_full;
  assign tx_pop_ok  = tx_ready && !tx_empty;
  assign rx_push_ok = rx_valid && !rx_full;
  assign rx_pop_ok  = rx_rd_req && !rx_empty;

  dcf_tag_fifo #(.DEPTH(TX_DEPTH), .DW(WORD_W), .TW(CHAN_W)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_we), .push_data(bus_wdata), .push_tag(tx_sel_chan),
    .pop(tx_ready), .head_data(tx_data), .head_tag(tx_chan),
    .count(tx_cnt), .empty(tx_empty), .full(tx_full)
  );

  dcf_tag_fifo #(.DEPTH(RX_DEPTH), .DW(WORD_W), .TW(CHAN_W)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_valid), .push_data(rx_data), .push_tag(rx_chan),
    .pop(rx_rd_req), .head_data(rx_head_data), .head_tag(rx_head_chan),
    .count(rx_cnt), .empty(rx_empty), .full(rx_full)
  );

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  // threshold selectors: [3:2] transmit, [1:0] receive
  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_thr <= '0;
    else if (cfg_we) cfg_thr <= bus_wdata[19:16];
  end

  dcf_thr_eval #(.DEPTH(TX_DEPTH), .RX_SIDE(1'b0)) u_txthr (
    .mode(cfg_thr[3:2]), .count(tx_cnt), .hit(tx_hit)
  );
  dcf_thr_eval #(.DEPTH(RX_DEPTH), .RX_SIDE(1'b1)) u_rxthr (
    .mode(cfg_thr[1:0]), .count(rx_cnt), .hit(rx_hit)
  );

  assign irq = tx_hit || rx_hit;

  assign cfg_word  = {12'h000, cfg_thr, 8'(TX_DEPTH), 8'(RX_DEPTH)};
  assign stat_word = {8'(tx_cnt), 8'(rx_cnt), 8'h00,
                      rx_empty ? 4'h0 : rx_head_chan,
                      rx_empty, rx_full, tx_empty, tx_full};

  always_comb begin
    case (rsel)
      RSEL_CFG:  bus_rdata = cfg_word;
      RSEL_STAT: bus_rdata = stat_word;
      RSEL_RXD:  bus_rdata = rx_empty ? '0 : rx_head_data;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  localparam int TX_CW   = $clog2(TX_DEPTH + 1),
  localparam int RX_CW   = $clog2(RX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_we,
  input logic             tx_full,
  input logic             tx_push_ok,
  input logic             tx_pop_ok,
  input logic [TX_CW-1:0] tx_cnt,
  input logic             rx_push_ok,
  input logic             rx_pop_ok,
  input logic             rx_rd_req,
  input logic             rx_empty,
  input logic             rx_full,
  input logic             rx_ready,
  input logic [RX_CW-1:0] rx_cnt,
  input logic [31:0]      bus_rdata,
  input logic [3:0]       cfg_thr,
  input logic             irq
);
  // R4
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_we && tx_full && !tx_pop_ok |=> $stable(tx_cnt));
  // R6
  rx_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_req && rx_empty |-> bus_rdata == 32'h0);
  // R10
  tx_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_ok && tx_pop_ok |=> $stable(tx_cnt));
  // R10
  rx_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_ok && rx_pop_ok |=> $stable(rx_cnt));
  // R5
  rx_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_ready);
  // R1
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_thr == 4'h0 |-> !irq);
  // R7
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tx_cnt) <= TX_DEPTH);
endmodule

bind dbgchan_fifo_periph dcf_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_we(tx_we), .tx_full(tx_full),
  .tx_push_ok(tx_push_ok), .tx_pop_ok(tx_pop_ok), .tx_cnt(tx_cnt),
  .rx_push_ok(rx_push_ok), .rx_pop_ok(rx_pop_ok), .rx_rd_req(rx_rd_req),
  .rx_empty(rx_empty), .rx_full(rx_full), .rx_ready(rx_ready), .rx_cnt(rx_cnt),
  .bus_rdata(bus_rdata), .cfg_thr(cfg_thr), .irq(irq)
);

// File: tb/sim_dbgchan_fifo_periph.sv
module sim_dbgchan_fifo_periph;
  localparam int TXD = 8;
  localparam int RXD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic [3:0]  tx_chan;
  logic        rx_valid = 1'b0, rx_ready;
  logic [31:0] rx_data = '0;
  logic [3:0]  rx_chan = '0;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  logic [35:0] tx_q[$];
  logic [35:0] rx_q[$];
  logic [3:0]  m_cfg = '0;

  always #4 clk = ~clk;

  dbgchan_fifo_periph u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_chan(tx_chan),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_chan(rx_chan),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic bit is_tx(input logic [7:0] a);
    return (a >= 8'h20) && (a < 8'hA0) && (a[2:0] == 3'd0);
  endfunction

  function automatic logic [31:0] exp_rd();
    bit rxe;
    rxe = (rx_q.size() == 0);
    if (!bus_rd) return 32'h0;
    case (bus_addr)
      8'h08: return {12'h0, m_cfg, 8'(TXD), 8'(RXD)};
      8'h10: return {8'(tx_q.size()), 8'(rx_q.size()), 8'h00,
                     rxe ? 4'h0 : rx_q[0][35:32], rxe,
                     rx_q.size() == RXD, tx_q.size() == 0, tx_q.size() == TXD};
      8'h18: return rxe ? 32'h0 : rx_q[0][31:0];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag();
    case (bus_addr)
      8'h08: return "R2";
      8'h10: return "R7";
      8'h18: return (rx_q.size() == 0) ? "R6" : "R5";
      default: return "R11";
    endcase
  endfunction

  function automatic logic exp_irq();
    int t, r;
    logic th, rh;
    t = tx_q.size();
    r = rx_q.size();
    case (m_cfg[3:2])
      2'd1: th = (t == 0);
      2'd2: th = (t < TXD);
      2'd3: th = (4 * t <= TXD);
      default: th = 1'b0;
    endcase
    case (m_cfg[1:0])
      2'd1: rh = (r == RXD);
      2'd2: rh = (r > 0);
      2'd3: rh = (4 * r >= 3 * RXD);
      default: rh = 1'b0;
    endcase
    return th | rh;
  endfunction

  // reference model update
  always @(posedge clk) begin : model
    bit t_push, t_pop, r_push, r_pop;
    cycles++;
    if (!rst_n) begin
      tx_q.delete();
      rx_q.delete();
      m_cfg = '0;
    end else begin
      t_push = bus_wr && is_tx(bus_addr) && (tx_q.size() < TXD);
      t_pop  = tx_ready && (tx_q.size() > 0);
      r_push = rx_valid && (rx_q.size() < RXD);
      r_pop  = bus_rd && (bus_addr == 8'h18) && (rx_q.size() > 0);
      if (t_pop) void'(tx_q.pop_front());
      if (t_push) tx_q.push_back({4'((bus_addr - 8'h20) >> 3), bus_wdata});
      if (r_pop) void'(rx_q.pop_front());
      if (r_push) rx_q.push_back({rx_chan, rx_data});
      if (bus_wr && bus_addr == 8'h08) m_cfg = bus_wdata[19:16];
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 R9 irq", 32'(irq), 32'(exp_irq()));
      chk("R3 tx_valid", 32'(tx_valid), 32'(tx_q.size() > 0));
      if (tx_q.size() > 0) begin
        chk("R3 tx_data", tx_data, tx_q[0][31:0]);
        chk("R3 tx_chan", 32'(tx_chan), 32'(tx_q[0][35:32]));
      end
      chk("R5 rx_ready", 32'(rx_ready), 32'(rx_q.size() < RXD));
      chk(rd_tag(), bus_rdata, exp_rd());
    end
  end

  task automatic cyc(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d,
                     input logic tr, input logic rv, input logic [31:0] rdat, input logic [3:0] rc);
    @(posedge clk);
    #2;
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    tx_ready = tr; rx_valid = rv; rx_data = rdat; rx_chan = rc;
  endtask

  task automatic idle(input int n);
    repeat (n) cyc(0, 0, 8'h00, 32'h0, 0, 0, 32'h0, 4'h0);
  endtask

  task automatic rd(input logic [7:0] a);
    cyc(0, 1, a, 32'h0, 0, 0, 32'h0, 4'h0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1, 0, a, d, 0, 0, 32'h0, 4'h0);
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] lf;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;

    rd(8'h10);
    @(negedge clk); chk("R1 status", bus_rdata, 32'h0000000A); chk("R1 irq", 32'(irq), 32'h0);
    rd(8'h08);
    @(negedge clk); chk("R2 cfg reset", bus_rdata, 32'h00000808);
    wr(8'h08, 32'hFFFFFFFF);
    rd(8'h08);
    @(negedge clk); chk("R2 cfg writable", bus_rdata, 32'h000F0808);
    wr(8'h08, 32'h0);

    // R3 R4: fill with ten writes, two dropped
    for (int i = 0; i < 10; i++) wr(8'(32 + 8 * i), 32'hA0000000 + 32'(i));
    rd(8'h10);
    @(negedge clk);
    chk("R4 tx count", 32'(bus_rdata[31:24]), 32'd8);
    chk("R4 head kept", tx_data, 32'hA0000000);

    // R8: drain under empty mode
    wr(8'h08, 32'h00040000);
    repeat (8) cyc(0, 0, 8'h00, 32'h0, 1, 0, 32'h0, 4'h0);
    idle(1);
    @(negedge clk); chk("R8 empty irq", 32'(irq), 32'h1);
    wr(8'h08, 32'h00080000);
    wr(8'h08, 32'h000C0000);
    wr(8'h08, 32'h00010000);

    // R5 R9: overfill RX
    for (int i = 0; i < 10; i++) cyc(0, 0, 8'h00, 32'h0, 0, 1, 32'hB0000000 + 32'(i), 4'(i + 3));
    idle(1);
    @(negedge clk); chk("R9 full irq", 32'(irq), 32'h1); chk("R5 ready low", 32'(rx_ready), 32'h0);
    rd(8'h10);
    @(negedge clk);
    chk("R7 rx count", 32'(bus_rdata[23:16]), 32'd8);
    chk("R5 head chan", 32'(bus_rdata[7:4]), 32'd3);
    for (int k = 0; k < 3; k++) begin
      rd(8'h18);
      @(negedge clk); chk("R5 rx word", bus_rdata, 32'hB0000000 + 32'(k));
    end
    wr(8'h08, 32'h00030000);
    idle(1);
    @(negedge clk); chk("R9 near full off", 32'(irq), 32'h0);
    wr(8'h08, 32'h00020000);
    for (int k = 0; k < 5; k++) rd(8'h18);
    rd(8'h18);
    @(negedge clk); chk("R6 empty read", bus_rdata, 32'h0);
    rd(8'h10);
    @(negedge clk); chk("R6 rx count", 32'(bus_rdata[23:16]), 32'd0);

    // R10: simultaneous push and pop
    for (int i = 0; i < 3; i++) wr(8'(32 + 8 * i), 32'hC0000000 + 32'(i));
    cyc(1, 0, 8'h48, 32'hC5, 1, 0, 32'h0, 4'h0);
    rd(8'h10);
    @(negedge clk); chk("R10 tx count", 32'(bus_rdata[31:24]), 32'd3);
    cyc(0, 0, 8'h00, 32'h0, 0, 1, 32'hD0, 4'h7);
    cyc(0, 0, 8'h00, 32'h0, 0, 1, 32'hD1, 4'h8);
    cyc(0, 1, 8'h18, 32'h0, 0, 1, 32'hD2, 4'h9);
    rd(8'h10);
    @(negedge clk); chk("R10 rx count", 32'(bus_rdata[23:16]), 32'd2);

    // R11: writes that must do nothing
    wr(8'h00, 32'hFFFFFFFF);
    wr(8'h10, 32'hFFFFFFFF);
    wr(8'h18, 32'hFFFFFFFF);
    wr(8'h21, 32'hFFFFFFFF);
    wr(8'hA0, 32'hFFFFFFFF);
    rd(8'h00);
    @(negedge clk); chk("R11 offset 0", bus_rdata, 32'h0);
    rd(8'h10);
    @(negedge clk);
    chk("R11 tx count", 32'(bus_rdata[31:24]), 32'd3);
    chk("R11 rx count", 32'(bus_rdata[23:16]), 32'd2);
    rd(8'h20);

    // pseudo-random collisions
    lf = 32'h1234_5678;
    for (int n = 0; n < 1200; n++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      case (lf[2:0])
        3'd0, 3'd1: cyc(1, 0, 8'(32 + 8 * lf[7:4]), lf, lf[16], lf[17], ~lf, lf[21:18]);
        3'd2: cyc(0, 1, 8'h18, 32'h0, lf[16], lf[17], lf ^ 32'h5A5A, lf[21:18]);
        3'd3: cyc(0, 1, 8'h10, 32'h0, lf[16], lf[17], lf, lf[21:18]);
        3'd4: cyc(1, 0, 8'h08, lf, lf[16], lf[17], lf, lf[21:18]);
        3'd5: cyc(0, 1, lf[15:8], 32'h0, lf[16], lf[17], lf, lf[21:18]);
        default: cyc(0, 0, 8'h00, 32'h0, lf[16], lf[17], lf, lf[21:18]);
      endcase
    end
    idle(3);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule